// File: doc/BRIEF.md
# GPIO Bank Controller with Pin Event Interrupts

This block controls a bank of general-purpose pins through a small 32-bit register bus. Each pin has a direction bit and an output data bit. Software changes output data bits through separate set and clear addresses, so one pin can change without a read-modify-write of the others. Incoming pin levels pass through a synchronizer and can be read back as a word.

Every pin has four independent trigger masks: low level, high level, rising edge and falling edge. Any detected event marks the pin in a write-one-to-clear status word. An enable mask, changed through separate set and clear addresses, selects which pending pins drive the single combined interrupt output. Software reads the status word, writes the same value back to clear it, and serves the pins it found.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset the direction word is all ones, output data is zero, all trigger masks and the enable mask are zero, and `irq` is low.
- R2: Direction bit value 1 makes a pin an input and 0 makes it a driven output. The word is read and written at 0x134 and appears on `pin_oe_n`.
- R3: A write to 0x194 sets every output data bit whose write-data bit is 1. A write to 0x190 clears every output data bit whose write-data bit is 1. Bits written as 0 keep their value. The output data word is read at 0x13C and drives `pin_out`.
- R4: A read of 0x138 returns the pin levels after a two-flop synchronizer, so a pin change is visible two clock edges after it is applied.
- R5: Trigger masks sit at 0x140 (low level), 0x144 (high level), 0x148 (rising edge) and 0x14C (falling edge). Any combination may be enabled per pin. An edge is a difference between the synchronized level and its value one clock earlier. Any event sets the pin's status bit whether or not the pin is enabled.
- R6: A pin with both level masks set has its status bit set continuously, even right after it is cleared.
- R7: The status word at 0x2C is write-one-to-clear. Writing back the value just read clears those bits and no others.
- R8: A write to 0x34 sets enable bits and a write to 0x38 clears enable bits, each where write data is 1. A read of either address returns the enable mask.
- R9: `irq` is the OR of status AND enable, registered once. It stays low while the enable mask is zero.
- R10: When a new event on a pin and a write-one-to-clear of that pin happen in the same cycle, the status bit stays set.
- R11: A read of any address not listed above returns zero. Read data appears on `bus_rdata` one clock after `bus_re` is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output data to the pads |
| pin_oe_n | output | 32 | Direction, 1 = input (driver off) |
| irq | output | 1 | Combined interrupt request |

## Verification
A detected pin event and a status clear from the bus can land on the same clock edge, and the event must win. The bench provokes this two ways. It clears a pin that has both level masks set, so an event occurs on every cycle. It also times a status clear so that it hits the exact edge where a rising-edge event is captured, counting the synchronizer stages from when the pin is driven. In both cases the status word is read back and the bit must still be set, while pins cleared in the same write without a new event must read zero.

// File: rtl/gpio_bank_pkg.sv
// Package: register addresses and bus sizing shared by the GPIO bank modules.
// Assumes byte addressing with 32-bit aligned registers.
package gpio_bank_pkg;
    localparam int BUS_ADDR_W = 12;
    localparam logic [BUS_ADDR_W-1:0] A_IRQ_STAT   = 12'h02C;
    localparam logic [BUS_ADDR_W-1:0] A_IRQ_EN_SET = 12'h034;
    localparam logic [BUS_ADDR_W-1:0] A_IRQ_EN_CLR = 12'h038;
    localparam logic [BUS_ADDR_W-1:0] A_DIR        = 12'h134;
    localparam logic [BUS_ADDR_W-1:0] A_DIN        = 12'h138;
    localparam logic [BUS_ADDR_W-1:0] A_DOUT       = 12'h13C;
    localparam logic [BUS_ADDR_W-1:0] A_TRIG_LO    = 12'h140;
    localparam logic [BUS_ADDR_W-1:0] A_TRIG_HI    = 12'h144;
    localparam logic [BUS_ADDR_W-1:0] A_TRIG_RISE  = 12'h148;
    localparam logic [BUS_ADDR_W-1:0] A_TRIG_FALL  = 12'h14C;
    localparam logic [BUS_ADDR_W-1:0] A_DOUT_CLR   = 12'h190;
    localparam logic [BUS_ADDR_W-1:0] A_DOUT_SET   = 12'h194;

    // Per-pin trigger mask bundle
    typedef struct packed {
        logic lo;
        logic hi;
        logic rise;
        logic fall;
    } trig_sel_t;
endpackage

// File: rtl/gpio_pin_sync.sv
// Module: multi-flop synchronizer for pin levels plus a one-cycle history copy.
// Assumes pin inputs are asynchronous; the last stage and its delayed copy
// are used for level and edge detection downstream.
module gpio_pin_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] level_prev
);
    logic [WIDTH-1:0] chain [STAGES];
    logic [WIDTH-1:0] prev_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Shift the pin levels one stage closer to the clock domain
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else if (s == 0) chain[s] <= raw_in;
                else chain[s] <= chain[(s > 0) ? s-1 : 0];
            end
        end
    endgenerate

    // Keep the previous synchronized level for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else prev_q <= chain[STAGES-1];
    end

    assign level      = chain[STAGES-1];
    assign level_prev = prev_q;
endmodule

// File: rtl/gpio_trig_detect.sv
// Module: per-pin event detection from synchronized levels and trigger masks.
// Assumes level and level_prev come from the same synchronizer; purely
// combinational, one event bit per pin per cycle.
module gpio_trig_detect #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] level_prev,
    input  logic [WIDTH-1:0] en_lo,
    input  logic [WIDTH-1:0] en_hi,
    input  logic [WIDTH-1:0] en_rise,
    input  logic [WIDTH-1:0] en_fall,
    output logic [WIDTH-1:0] event_hit
);
    import gpio_bank_pkg::*;

    generate
        for (genvar p = 0; p < WIDTH; p++) begin : g_pin
            trig_sel_t sel;
            logic      rose, fell;
            assign sel  = '{lo: en_lo[p], hi: en_hi[p], rise: en_rise[p], fall: en_fall[p]};
            assign rose = level[p] & ~level_prev[p];
            assign fell = ~level[p] & level_prev[p];
            // Combine the four enabled detectors for this pin
            always_comb begin
                event_hit[p] = (sel.lo & ~level[p]) | (sel.hi & level[p]) |
                               (sel.rise & rose) | (sel.fall & fell);
            end
        end
    endgenerate
endmodule

// File: rtl/gpio_irq_unit.sv
// Module: pending status (write-one-to-clear), enable mask with set/clear
// ports, and the registered combined interrupt. Assumes clear and set
// masks are zero on cycles without a matching bus write.
module gpio_irq_unit #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] event_hit,
    input  logic [WIDTH-1:0] stat_clr,
    input  logic [WIDTH-1:0] en_set,
    input  logic [WIDTH-1:0] en_clr,
    output logic [WIDTH-1:0] status,
    output logic [WIDTH-1:0] enable,
    output logic             irq
);
    logic [WIDTH-1:0] status_q, enable_q;
    logic             irq_q;

    // Latch events; a new event outranks a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else status_q <= (status_q & ~stat_clr) | event_hit;
    end

    // Apply enable set and clear requests
    always_ff @(posedge clk) begin
        if (!rst_n) enable_q <= '0;
        else enable_q <= (enable_q | en_set) & ~en_clr;
    end

    // Register the combined request
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else irq_q <= |(status_q & enable_q);
    end

    assign status = status_q;
    assign enable = enable_q;
    assign irq    = irq_q;

    assert_event_latched_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|event_hit) |=> ((status_q & $past(event_hit)) == $past(event_hit)));

    assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat_clr & ~event_hit)) |=> ((status_q & $past(stat_clr & ~event_hit)) == '0));

    assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(stat_clr & event_hit)) |=> ((status_q & $past(stat_clr & event_hit)) != '0));

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_q == '0) |=> !irq_q);
endmodule

// File: rtl/gpio_bank_ctrl.sv
// Module: GPIO bank top. Decodes the register bus, holds direction, output
// data and trigger masks, and returns registered read data.
// Assumes one access per cycle; bus_we and bus_re are not both used at once.
module gpio_bank_ctrl #(
    parameter int PINS        = 32,
    parameter int ADDR_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [PINS-1:0]   bus_wdata,
    input  logic              bus_re,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe_n,
    output logic              irq
);
    import gpio_bank_pkg::*;

    localparam logic [PINS-1:0] ALL_ONES = {PINS{1'b1}};

    logic [PINS-1:0] dir_q, dout_q, lo_q, hi_q, rise_q, fall_q, rdata_q;
    logic [PINS-1:0] lvl, lvl_prev, ev, stat, en;
    logic [PINS-1:0] stat_clr, en_set, en_clr;
    logic [PINS-1:0] rd_mux;

    // Write strobe for one register address
    function automatic logic hit(input logic [ADDR_W-1:0] a,
                                 input logic [BUS_ADDR_W-1:0] ref_a);
        return (a == ADDR_W'(ref_a));
    endfunction

    assign stat_clr = (bus_we && hit(bus_addr, A_IRQ_STAT))   ? bus_wdata : '0;
    assign en_set   = (bus_we && hit(bus_addr, A_IRQ_EN_SET)) ? bus_wdata : '0;
    assign en_clr   = (bus_we && hit(bus_addr, A_IRQ_EN_CLR)) ? bus_wdata : '0;

    // Direction register: reset to all inputs
    always_ff @(posedge clk) begin
        if (!rst_n) dir_q <= ALL_ONES;
        else if (bus_we && hit(bus_addr, A_DIR)) dir_q <= bus_wdata;
    end

    // Output data: plain write plus atomic set and clear
    always_ff @(posedge clk) begin
        if (!rst_n) dout_q <= '0;
        else if (bus_we && hit(bus_addr, A_DOUT)) dout_q <= bus_wdata;
        else if (bus_we && hit(bus_addr, A_DOUT_SET)) dout_q <= dout_q | bus_wdata;
        else if (bus_we && hit(bus_addr, A_DOUT_CLR)) dout_q <= dout_q & ~bus_wdata;
    end

    // Trigger mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0; hi_q <= '0; rise_q <= '0; fall_q <= '0;
        end else if (bus_we) begin
            if (hit(bus_addr, A_TRIG_LO))   lo_q   <= bus_wdata;
            if (hit(bus_addr, A_TRIG_HI))   hi_q   <= bus_wdata;
            if (hit(bus_addr, A_TRIG_RISE)) rise_q <= bus_wdata;
            if (hit(bus_addr, A_TRIG_FALL)) fall_q <= bus_wdata;
        end
    end

    gpio_pin_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_in(pin_in),
        .level(lvl), .level_prev(lvl_prev)
    );

    gpio_trig_detect #(.WIDTH(PINS)) u_detect (
        .level(lvl), .level_prev(lvl_prev),
        .en_lo(lo_q), .en_hi(hi_q), .en_rise(rise_q), .en_fall(fall_q),
        .event_hit(ev)
    );

    gpio_irq_unit #(.WIDTH(PINS)) u_irq (
        .clk(clk), .rst_n(rst_n), .event_hit(ev),
        .stat_clr(stat_clr), .en_set(en_set), .en_clr(en_clr),
        .status(stat), .enable(en), .irq(irq)
    );

    // Read multiplexer; unmapped addresses give zero
    always_comb begin
        rd_mux = '0;
        if      (hit(bus_addr, A_IRQ_STAT))   rd_mux = stat;
        else if (hit(bus_addr, A_IRQ_EN_SET)) rd_mux = en;
        else if (hit(bus_addr, A_IRQ_EN_CLR)) rd_mux = en;
        else if (hit(bus_addr, A_DIR))        rd_mux = dir_q;
        else if (hit(bus_addr, A_DIN))        rd_mux = lvl;
        else if (hit(bus_addr, A_DOUT))       rd_mux = dout_q;
        else if (hit(bus_addr, A_TRIG_LO))    rd_mux = lo_q;
        else if (hit(bus_addr, A_TRIG_HI))    rd_mux = hi_q;
        else if (hit(bus_addr, A_TRIG_RISE))  rd_mux = rise_q;
        else if (hit(bus_addr, A_TRIG_FALL))  rd_mux = fall_q;
    end

    // Capture read data on the read strobe
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else if (bus_re) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
    assign pin_out   = dout_q;
    assign pin_oe_n  = dir_q;

    assert_set_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(A_DOUT_SET)) |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

    assert_clr_port_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(A_DOUT_CLR)) |=> ((pin_out & $past(bus_wdata)) == '0));

    assert_dir_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_we) |=> $stable(pin_oe_n));
endmodule

// File: tb/gpio_bank_ctrl_tb.sv
// Bench: sweeps trigger combinations and pin transitions on every pin with a
// 20 ns clock; inputs driven and outputs sampled on the falling edge.
module gpio_bank_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_we = 1'b0, bus_re = 1'b0;
    logic [31:0] bus_wdata = '0, pin_in = '0;
    logic [31:0] bus_rdata, pin_out, pin_oe_n;
    logic        irq;
    int          n_checks = 0, n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    gpio_bank_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe_n(pin_oe_n), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] lvl_ev(input logic [31:0] lo, input logic [31:0] hi,
                                           input logic [31:0] v);
        return (lo & ~v) | (hi & v);
    endfunction

    initial begin
        logic [31:0] r, model_dout, lo, hi, ri, fa, exp;
        logic [31:0] pats [4];
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2 reset state
        rd(12'h134, r); check("R1 dir reset", r, 32'hFFFF_FFFF);
        check("R2 oe_n reset", pin_oe_n, 32'hFFFF_FFFF);
        rd(12'h13C, r); check("R1 dout reset", r, 32'h0);
        rd(12'h034, r); check("R1 enable reset", r, 32'h0);
        check("R1 irq reset", {31'b0, irq}, 32'h0);

        // R2 direction write and pin view
        wr(12'h134, 32'h0F0F_3C3C);
        rd(12'h134, r); check("R2 dir readback", r, 32'h0F0F_3C3C);
        check("R2 oe_n pins", pin_oe_n, 32'h0F0F_3C3C);

        // R3 atomic set/clear sweep with model
        model_dout = '0;
        for (int k = 0; k < 24; k++) begin
            logic [31:0] m;
            m = 32'h9E37_79B9 * (k + 1) ^ (32'h1 << k);
            if (k % 2 == 0) begin wr(12'h194, m); model_dout |= m; end
            else begin wr(12'h190, m); model_dout &= ~m; end
            rd(12'h13C, r); check("R3 dout set/clr", r, model_dout);
            check("R3 pin_out", pin_out, model_dout);
        end

        // R4 synchronized input view
        for (int k = 0; k < 6; k++) begin
            logic [31:0] v;
            v = 32'hA5C3_0F81 * (k + 3);
            pin_in = v;
            @(negedge clk);
            rd(12'h138, r); check("R4 din early", r, (k == 0) ? 32'h0 : 32'hA5C3_0F81 * (k + 2));
            @(negedge clk);
            rd(12'h138, r); check("R4 din settled", r, v);
        end

        // R5/R6 trigger sweep: pin p uses combination p%16
        lo = '0; hi = '0; ri = '0; fa = '0;
        for (int p = 0; p < 32; p++) begin
            lo[p] = p[0]; hi[p] = p[1]; ri[p] = p[2]; fa[p] = p[3];
        end
        wr(12'h140, lo); wr(12'h144, hi); wr(12'h148, ri); wr(12'h14C, fa);
        pats[0] = 32'h0; pats[1] = 32'hFFFF_FFFF; pats[2] = 32'h0; pats[3] = 32'hFFFF_FFFF;
        for (int a = 0; a < 2; a++) begin
            for (int b = 0; b < 2; b++) begin
                logic [31:0] v0, v1;
                v0 = a ? 32'hFFFF_FFFF : 32'h0;
                v1 = b ? 32'hFFFF_FFFF : 32'h0;
                pin_in = v0; idle(5);
                wr(12'h02C, 32'hFFFF_FFFF); idle(1);
                rd(12'h02C, r); check("R6 status after clear", r, lvl_ev(lo, hi, v0));
                pin_in = v1; idle(6);
                exp = lvl_ev(lo, hi, v0) | lvl_ev(lo, hi, v1) |
                      (ri & v1 & ~v0) | (fa & ~v1 & v0);
                rd(12'h02C, r); check("R5 status events", r, exp);
            end
        end
        // R6 both levels stay set on a pin
        wr(12'h02C, 32'h0000_0008); idle(1);
        rd(12'h02C, r); check("R6 both levels continuous", r & 32'h8, 32'h8);

        // R7 write-back clear with edge-only masks
        wr(12'h140, 0); wr(12'h144, 0); wr(12'h148, 32'hFFFF_FFFF); wr(12'h14C, 0);
        pin_in = 32'h0; idle(5); wr(12'h02C, 32'hFFFF_FFFF); idle(1);
        pin_in = 32'h00FF_00F0; idle(5);
        rd(12'h02C, r); check("R7 pending before clear", r, 32'h00FF_00F0);
        wr(12'h02C, 32'h0000_00F0); idle(1);
        rd(12'h02C, r); check("R7 partial clear", r, 32'h00FF_0000);
        wr(12'h02C, r); idle(1);
        rd(12'h02C, r); check("R7 write-back clear", r, 32'h0);

        // R8/R9 enable mask and irq
        pin_in = 32'h00FF_00F1; idle(5);
        check("R9 irq masked", {31'b0, irq}, 32'h0);
        wr(12'h034, 32'h8000_0001); idle(3);
        rd(12'h038, r); check("R8 enable via clr addr", r, 32'h8000_0001);
        check("R9 irq asserted", {31'b0, irq}, 32'h1);
        wr(12'h038, 32'h0000_0001); idle(3);
        rd(12'h034, r); check("R8 enable after clear", r, 32'h8000_0000);
        check("R9 irq after disable", {31'b0, irq}, 32'h0);
        wr(12'h038, 32'hFFFF_FFFF);

        // R10 same-cycle event and clear on the rising edge
        wr(12'h02C, 32'hFFFF_FFFF); idle(1);
        pin_in = 32'h00FF_00F1 | 32'h0000_0100;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        wr(12'h02C, 32'h0000_0101); idle(1);
        rd(12'h02C, r); check("R10 event beats clear", r, 32'h0000_0100);

        // R11 unmapped reads return zero
        wr(12'h140, 32'h1234_5678);
        rd(12'h140, r); check("R11 mapped read", r, 32'h1234_5678);
        rd(12'h000, r); check("R11 unmapped 0x000", r, 32'h0);
        rd(12'h13A, r); check("R11 unmapped 0x13A", r, 32'h0);
        rd(12'hFFC, r); check("R11 unmapped 0xFFC", r, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule